// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA with Frame Error Drain

This block walks a circular list of transmit descriptors held in a word-addressed memory and sends each owned buffer to a byte-wide transmit port. Each descriptor takes three consecutive words: a status word, a length word and a buffer word address. A frame may be split across several descriptors. The frame-position field marks which descriptor opens the frame, which ones continue it and which one closes it. Once the block has handled a descriptor, it writes the status word back with the ownership bit cleared. It then moves on to the next descriptor in the ring. The pointer returns to the ring base after a descriptor that carries the last-entry mark.

The transmitter can report a fault while a buffer is being sent. When that happens, the block stops sending and enters a drain walk through the rest of the same frame. In this walk it only reads each status word and writes it back with ownership cleared. It moves no buffer data. The fault code and an error flag go only into the descriptor that closes the frame. When the interrupt is enabled, a one-cycle interrupt follows that final write-back. Software arms the block with an enable level and a start pulse. The block stops by itself when it finds a descriptor it does not own.

Top module: `tdma_tx_ring`

## Requirements
- R1: After reset, tx_valid, irq, mem_rd and mem_wr are all low, and the block stays idle until a start pulse arrives.
- R2: A start pulse is ignored while enable is low. While idle and disabled, the descriptor pointer is held at ring_base.
- R3: The descriptor layout is as follows. The status word holds ownership in bit 31, the last-entry mark in bit 30, the frame position in bits 29:28, the error flag in bit 27 and a 4-bit status code in bits 3:0. The second word holds the byte count in bits 15:0. The third word holds the buffer word address. Buffer byte k is taken from word address+k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R4: The buffer's bytes are offered in order on tx_data with tx_valid. A byte counts as sent on a cycle where tx_valid and tx_ready are high and tx_error is low. While tx_ready is low, the offered byte is held unchanged.
- R5: After a normal descriptor, the status word is written back with ownership 0, the last-entry mark and position kept, the error flag 0 and the status code 0. The walk then continues with the next descriptor. It stops at a descriptor whose ownership bit is 0.
- R6: After a descriptor with the last-entry mark, the next fetch is from ring_base. Otherwise the next fetch is three words further on.
- R7: If tx_error is high while a byte is offered, tx_valid is low from the next cycle. That byte is not sent, and the current descriptor's ownership is cleared in its write-back.
- R8: After a fault, each later owned descriptor of the frame has only its status word read and written back, with ownership cleared. No length, address or buffer word is read, and no byte is sent.
- R9: The descriptor that closes the faulty frame has position 2'b01, or 2'b11 for a single-descriptor frame. Its write-back sets the error flag to 1 and the status code to tx_err_code as sampled at the fault. All other descriptors of that frame keep the error flag at 0.
- R10: With irq_en high, irq is a one-cycle pulse in the cycle after the closing write-back. With irq_en low, no pulse occurs.
- R11: A fault in the same cycle as the handshake of a buffer's last byte counts as a fault. That byte is not sent, and the fault status is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows start; while low and idle, the pointer returns to ring_base |
| start | input | 1 | One-cycle pulse to resume the ring walk |
| irq_en | input | 1 | Error interrupt enable |
| ring_base | input | ADDR_W | Word address of the first descriptor |
| mem_rd | output | 1 | Memory read strobe; data returns one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| tx_valid | output | 1 | A byte is offered on tx_data |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_error | input | 1 | Transmitter fault indication |
| tx_err_code | input | 4 | Fault code, recorded with tx_error |
| irq | output | 1 | Error interrupt pulse |

## Verification
Two functions can collide: completing a buffer's last byte and taking a transmitter fault. The bench provokes this by counting accepted bytes and raising tx_error in exactly the cycle that offers the final byte, with tx_ready high. The outcome is judged at the ports and in the memory model. The byte count must stop one short, the descriptor's write-back must carry the error flag and the sampled code, and the interrupt must stay silent because it was disabled for that case. The same counting method places faults partway through the first buffer of a four-descriptor frame and of a single-descriptor frame. In those cases the bench also checks that no length, address or buffer word is read after the fault.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

   localparam int WORD_W     = 32;
   localparam int BYTE_W     = 8;
   localparam int DESC_WORDS = 3;
   localparam int CODE_W     = 4;

   typedef enum logic [1:0] {
      POS_CONT  = 2'b00,
      POS_END   = 2'b01,
      POS_START = 2'b10,
      POS_ONLY  = 2'b11
   } fpos_e;

   typedef struct packed {
      logic              own;
      logic              last_entry;
      fpos_e             pos;
      logic              err;
      logic [22:0]       rsvd;
      logic [CODE_W-1:0] code;
   } dstat_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_STAT,
      S_GET_STAT,
      S_RD_LEN,
      S_GET_LEN,
      S_RD_ADDR,
      S_GET_ADDR,
      S_RD_BUF,
      S_GET_BUF,
      S_SEND,
      S_WRITEBACK
   } tstate_e;

   function automatic logic closes_frame(input fpos_e p);
      return (p == POS_END) || (p == POS_ONLY);
   endfunction

endpackage

// File: rtl/tdma_ring_ptr.sv
module tdma_ring_ptr #(
   parameter int ADDR_W = 10,
   parameter int STEP   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_base,
   input  logic [ADDR_W-1:0] base,
   input  logic              advance,
   input  logic              wrap,
   output logic [ADDR_W-1:0] ptr
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   generate
      if (STEP < 1 || STEP >= (1 << ADDR_W)) begin : g_bad_step
         $error("tdma_ring_ptr: STEP out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load_base)
         ptr <= base;
      else if (advance)
         ptr <= wrap ? base : ptr + STEP_V;
   end

   assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && wrap && !load_base) |=> (ptr == $past(base)))
      else $error("pointer did not return to ring base");

   assert_step_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !wrap && !load_base) |=> (ptr == $past(ptr) + STEP_V))
      else $error("pointer did not step by one descriptor");

endmodule

// File: rtl/tdma_byte_sel.sv
module tdma_byte_sel #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic [WORD_W-1:0] word,
   input  logic [IDX_W-1:0]  idx,
   output logic [BYTE_W-1:0] byte_o
);

   localparam int LANES = WORD_W / BYTE_W;

   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_ratio
         $error("tdma_byte_sel: word is not a whole number of bytes");
      end
      if ((1 << IDX_W) != LANES) begin : g_bad_idx
         $error("tdma_byte_sel: lane count must equal 2**IDX_W");
      end
   endgenerate

   logic [BYTE_W-1:0] lane [LANES];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane[i] = word[i*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign byte_o = lane[idx];

endmodule

// File: rtl/tdma_irq_pulse.sv
module tdma_irq_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic en,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else
         irq <= fire && en;
   end

   assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq)
      else $error("interrupt wider than one cycle");

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !en) |=> !irq)
      else $error("interrupt raised while disabled");

endmodule

// File: rtl/tdma_tx_ring.sv
module tdma_tx_ring
   import tdma_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               start,
   input  logic               irq_en,
   input  logic [ADDR_W-1:0]  ring_base,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   input  logic               tx_ready,
   input  logic               tx_error,
   input  logic [3:0]         tx_err_code,
   output logic               irq
);

   localparam int LANES = WORD_W / BYTE_W;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0]  LAST_LANE = IDX_W'(LANES - 1);
   localparam logic [LEN_W-1:0]  ONE_LEFT  = LEN_W'(1);
   localparam logic [ADDR_W-1:0] OFS_LEN   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] OFS_ADDR  = ADDR_W'(2);

   generate
      if (ADDR_W < 4 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("tdma_tx_ring: ADDR_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("tdma_tx_ring: LEN_W must lie in 1..16");
      end
   endgenerate

   tstate_e             state_q;
   logic                te_q;
   fpos_e               pos_q;
   logic [LEN_W-1:0]    rem_q;
   logic [ADDR_W-1:0]   bptr_q;
   logic [IDX_W-1:0]    bidx_q;
   logic [WORD_W-1:0]   word_q;
   logic                drain_q;
   logic [CODE_W-1:0]   code_q;
   logic [ADDR_W-1:0]   ptr;
   logic                wb_fire;
   dstat_t              rd_stat;
   dstat_t              wb_stat;
   logic                closing_fault;

   assign rd_stat       = dstat_t'(mem_rdata);
   assign closing_fault = drain_q && closes_frame(pos_q);
   assign wb_fire       = (state_q == S_WRITEBACK) && closing_fault;

   tdma_ring_ptr #(
      .ADDR_W (ADDR_W),
      .STEP   (DESC_WORDS)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_base ((state_q == S_IDLE) && !enable),
      .base      (ring_base),
      .advance   (state_q == S_WRITEBACK),
      .wrap      (te_q),
      .ptr       (ptr)
   );

   tdma_byte_sel #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W),
      .IDX_W  (IDX_W)
   ) u_sel (
      .word   (word_q),
      .idx    (bidx_q),
      .byte_o (tx_data)
   );

   tdma_irq_pulse u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (wb_fire),
      .en    (irq_en),
      .irq   (irq)
   );

   always_comb begin
      mem_rd   = 1'b0;
      mem_addr = ptr;
      unique case (state_q)
         S_RD_STAT: mem_rd = 1'b1;
         S_RD_LEN: begin
            mem_rd   = 1'b1;
            mem_addr = ptr + OFS_LEN;
         end
         S_RD_ADDR: begin
            mem_rd   = 1'b1;
            mem_addr = ptr + OFS_ADDR;
         end
         S_RD_BUF: begin
            mem_rd   = 1'b1;
            mem_addr = bptr_q;
         end
         default: ;
      endcase
   end

   always_comb begin
      wb_stat            = '0;
      wb_stat.own        = 1'b0;
      wb_stat.last_entry = te_q;
      wb_stat.pos        = pos_q;
      if (closing_fault) begin
         wb_stat.err  = 1'b1;
         wb_stat.code = code_q;
      end
   end

   assign mem_wr    = (state_q == S_WRITEBACK);
   assign mem_wdata = wb_stat;
   assign tx_valid  = (state_q == S_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         te_q    <= 1'b0;
         pos_q   <= POS_CONT;
         rem_q   <= '0;
         bptr_q  <= '0;
         bidx_q  <= '0;
         word_q  <= '0;
         drain_q <= 1'b0;
         code_q  <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (enable && start)
                  state_q <= S_RD_STAT;
            end
            S_RD_STAT: state_q <= S_GET_STAT;
            S_GET_STAT: begin
               te_q  <= rd_stat.last_entry;
               pos_q <= rd_stat.pos;
               if (!rd_stat.own)
                  state_q <= S_IDLE;
               else if (drain_q)
                  state_q <= S_WRITEBACK;
               else
                  state_q <= S_RD_LEN;
            end
            S_RD_LEN: state_q <= S_GET_LEN;
            S_GET_LEN: begin
               rem_q   <= mem_rdata[LEN_W-1:0];
               state_q <= S_RD_ADDR;
            end
            S_RD_ADDR: state_q <= S_GET_ADDR;
            S_GET_ADDR: begin
               bptr_q  <= mem_rdata[ADDR_W-1:0];
               bidx_q  <= '0;
               state_q <= (rem_q == '0) ? S_WRITEBACK : S_RD_BUF;
            end
            S_RD_BUF: state_q <= S_GET_BUF;
            S_GET_BUF: begin
               word_q  <= mem_rdata;
               state_q <= S_SEND;
            end
            S_SEND: begin
               if (tx_error) begin
                  drain_q <= 1'b1;
                  code_q  <= tx_err_code;
                  state_q <= S_WRITEBACK;
               end else if (tx_ready) begin
                  rem_q <= rem_q - ONE_LEFT;
                  if (rem_q == ONE_LEFT) begin
                     state_q <= S_WRITEBACK;
                  end else if (bidx_q == LAST_LANE) begin
                     bidx_q  <= '0;
                     bptr_q  <= bptr_q + OFS_LEN;
                     state_q <= S_RD_BUF;
                  end else begin
                     bidx_q <= bidx_q + IDX_W'(1);
                  end
               end
            end
            S_WRITEBACK: begin
               if (closing_fault)
                  drain_q <= 1'b0;
               state_q <= S_RD_STAT;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tx_valid && !mem_wr))
      else $error("activity right after reset");

   assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !tx_error) |=> (tx_valid && $stable(tx_data)))
      else $error("offered byte changed under back-pressure");

   assert_stop_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_error) |=> (!tx_valid && mem_wr))
      else $error("data kept flowing after a fault");

   assert_no_data_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drain_q |-> !tx_valid)
      else $error("byte offered during drain");

   assert_drain_reads_status_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_q && mem_rd) |-> (mem_addr == ptr))
      else $error("non-status read during drain");

   assert_irq_after_closing_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(mem_wr) && $past(mem_wdata[27])))
      else $error("interrupt not preceded by closing write-back");

   assert_wb_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr)
      else $error("back-to-back write-backs");

endmodule

// File: tb/tb_tdma_tx_ring.sv
module tb_tdma_tx_ring;

   localparam int AW   = 10;
   localparam int BASE = 16;
   localparam int BUF0 = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          enable, start, irq_en;
   logic [AW-1:0] ring_base;
   logic          mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          tx_valid, tx_ready, tx_error, irq;
   logic [7:0]    tx_data;
   logic [3:0]    tx_err_code;

   logic [31:0]   mem [0:(1<<AW)-1];
   logic [7:0]    cap [0:255];
   logic [7:0]    expb [0:255];
   int            cap_n, exp_n, irq_cnt, irq_flag_at, end_addr, bad_rd;
   bit            err_seen;
   int            n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   tdma_tx_ring #(.ADDR_W(AW), .LEN_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .irq_en(irq_en),
      .ring_base(ring_base), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .tx_error(tx_error),
      .tx_err_code(tx_err_code), .irq(irq)
   );

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready && !tx_error) begin
            cap[cap_n] = tx_data;
            cap_n++;
         end
         if (irq) begin
            irq_cnt++;
            irq_flag_at = int'(mem[end_addr][27]);
         end
         if (err_seen && mem_rd &&
             (int'(mem_addr) >= BUF0 || ((int'(mem_addr) - BASE) % 3) != 0))
            bad_rd++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_ring();
      @(posedge clk); #1;
      enable = 1'b0; irq_en = 1'b0; tx_ready = 1'b1; tx_error = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = '0;
      cap_n = 0; exp_n = 0; irq_cnt = 0; irq_flag_at = -1; bad_rd = 0; err_seen = 1'b0;
      end_addr = BASE;
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic put_desc(input int k, input bit te, input bit [1:0] pos,
                           input int len, input int buf_addr, input int seed);
      mem[BASE + 3*k]     = {1'b1, te, pos, 1'b0, 23'd0, 4'd0};
      mem[BASE + 3*k + 1] = 32'(len);
      mem[BASE + 3*k + 2] = 32'(buf_addr);
      for (int j = 0; j < len; j++) begin
         mem[buf_addr + j/4][8*(j%4) +: 8] = 8'(seed + 7*j);
         expb[exp_n] = 8'(seed + 7*j);
         exp_n++;
      end
   endtask

   task automatic kick();
      enable = 1'b1;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic fault_after(input int n, input bit [3:0] code);
      do @(posedge clk); while (cap_n < n);
      #1 tx_error = 1'b1; tx_err_code = code; err_seen = 1'b1;
      @(posedge clk); #1 tx_error = 1'b0;
      @(negedge clk);
      chk("R7", "tx_valid after fault", tx_valid, 0);
   endtask

   task automatic cmp_stream(input string req, input int n);
      chk(req, "byte count", cap_n, n);
      for (int i = 0; i < n && i < cap_n; i++)
         chk(req, $sformatf("byte %0d", i), cap[i], expb[i]);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "tx_valid", tx_valid, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "mem_rd", mem_rd, 0);
      chk("R1", "mem_wr", mem_wr, 0);
   endtask

   task automatic t_disabled();
      clear_ring();
      put_desc(0, 1'b0, 2'b11, 4, BUF0, 8'h10);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk("R2", "bytes while disabled", cap_n, 0);
      chk("R2", "owner untouched", mem[BASE][31], 1);
   endtask

   task automatic t_single();
      clear_ring();
      put_desc(0, 1'b0, 2'b11, 5, BUF0, 8'h21);
      kick();
      repeat (60) @(posedge clk);
      @(negedge clk);
      cmp_stream("R3", 5);
      chk("R5", "status word", mem[BASE], 32'h3000_0000);
      chk("R10", "no irq on clean frame", irq_cnt, 0);
   endtask

   task automatic t_multi();
      clear_ring();
      put_desc(0, 1'b0, 2'b10, 3, BUF0,      8'h31);
      put_desc(1, 1'b0, 2'b00, 6, BUF0 + 16, 8'h52);
      put_desc(2, 1'b0, 2'b01, 2, BUF0 + 32, 8'h73);
      kick();
      repeat (100) @(posedge clk);
      @(negedge clk);
      cmp_stream("R4", 11);
      chk("R5", "start status", mem[BASE],     32'h2000_0000);
      chk("R5", "cont status",  mem[BASE + 3], 32'h0000_0000);
      chk("R5", "end status",   mem[BASE + 6], 32'h1000_0000);
   endtask

   task automatic t_stall();
      clear_ring();
      put_desc(0, 1'b0, 2'b11, 6, BUF0, 8'h44);
      tx_ready = 1'b0;
      kick();
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R4", "no byte while stalled", cap_n, 0);
      chk("R4", "held valid", tx_valid, 1);
      chk("R4", "held byte", tx_data, expb[0]);
      @(posedge clk); #1 tx_ready = 1'b1;
      repeat (40) @(posedge clk);
      @(negedge clk);
      cmp_stream("R4", 6);
   endtask

   task automatic t_wrap();
      clear_ring();
      put_desc(0, 1'b0, 2'b11, 2, BUF0,      8'h61);
      put_desc(1, 1'b1, 2'b11, 2, BUF0 + 16, 8'h62);
      kick();
      repeat (60) @(posedge clk);
      mem[BASE][31] = 1'b1;
      expb[4] = expb[0]; expb[5] = expb[1];
      kick();
      repeat (60) @(posedge clk);
      @(negedge clk);
      cmp_stream("R6", 6);
      chk("R6", "wrapped descriptor released", mem[BASE][31], 0);
      chk("R6", "table-end kept", mem[BASE + 3], 32'h7000_0000);
   endtask

   task automatic t_fault_mid();
      clear_ring();
      irq_en = 1'b1;
      put_desc(0, 1'b0, 2'b10, 8, BUF0,      8'h81);
      put_desc(1, 1'b0, 2'b00, 4, BUF0 + 16, 8'h82);
      put_desc(2, 1'b0, 2'b00, 4, BUF0 + 32, 8'h83);
      put_desc(3, 1'b1, 2'b01, 4, BUF0 + 48, 8'h84);
      end_addr = BASE + 9;
      kick();
      fault_after(2, 4'hA);
      repeat (60) @(posedge clk);
      @(negedge clk);
      cmp_stream("R7", 2);
      chk("R7", "faulting desc status", mem[BASE],     32'h2000_0000);
      chk("R8", "drained cont 1",       mem[BASE + 3], 32'h0000_0000);
      chk("R8", "drained cont 2",       mem[BASE + 6], 32'h0000_0000);
      chk("R8", "non-status reads",     bad_rd, 0);
      chk("R9", "closing status",       mem[BASE + 9], 32'h5800_000A);
      chk("R10", "irq count",           irq_cnt, 1);
      chk("R10", "irq after write-back", irq_flag_at, 1);
   endtask

   task automatic t_fault_single();
      clear_ring();
      irq_en = 1'b1;
      put_desc(0, 1'b0, 2'b11, 6, BUF0, 8'h91);
      kick();
      fault_after(1, 4'h3);
      repeat (40) @(posedge clk);
      @(negedge clk);
      cmp_stream("R9", 1);
      chk("R9", "single-desc status", mem[BASE], 32'h3800_0003);
      chk("R8", "non-status reads", bad_rd, 0);
      chk("R10", "irq count", irq_cnt, 1);
   endtask

   task automatic t_fault_last_byte();
      clear_ring();
      put_desc(0, 1'b0, 2'b11, 3, BUF0, 8'hA1);
      kick();
      fault_after(2, 4'h5);
      repeat (40) @(posedge clk);
      @(negedge clk);
      cmp_stream("R11", 2);
      chk("R11", "fault recorded", mem[BASE], 32'h3800_0005);
      chk("R10", "no irq when disabled", irq_cnt, 0);
   endtask

   initial begin
      rst_n = 1'b0; enable = 1'b0; start = 1'b0; irq_en = 1'b0;
      ring_base = AW'(BASE); tx_ready = 1'b1; tx_error = 1'b0; tx_err_code = '0;
      cap_n = 0; exp_n = 0; irq_cnt = 0; irq_flag_at = -1; bad_rd = 0; err_seen = 1'b0;
      end_addr = BASE;
      for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_disabled();
      t_single();
      t_multi();
      t_stall();
      t_wrap();
      t_fault_mid();
      t_fault_single();
      t_fault_last_byte();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule